// File: doc/BRIEF.md
# Arithmetic/Logic Unit with Held Zero Flag

This block is the arithmetic/logic unit of a small single-cycle processor. Two operand words and a three-bit function code go in, and one result word comes out. Nothing is registered on the result path, so the result settles in the same cycle as its inputs. The processor routes that result to register write-back.

Next to the datapath sits one flip-flop, the zero flag. It records whether the most recent *arithmetic* operation produced an all-zero word. Bitwise and move operations pass through without touching it, so a later conditional branch still sees the outcome of the last add, subtract or compare. The compare function computes A minus B only to set the flag. Its result word is still driven, but the processor is expected not to write it back.

Top module: `zf_alu`

## Requirements
- R1: With `func_sel` = 3'b000 the result is `op_a & op_b`, bit by bit.
- R2: With `func_sel` = 3'b001 the result is `op_a | op_b`.
- R3: With `func_sel` = 3'b100 the result is `op_a ^ op_b`.
- R4: With `func_sel` = 3'b101 the result is `~op_a`; `op_b` is ignored.
- R5: With `func_sel` = 3'b110 the result is `op_b`; `op_a` is ignored.
- R6: With `func_sel` = 3'b010 the result is `op_a + op_b` modulo 2^WIDTH. No carry is reported.
- R7: With `func_sel` = 3'b011 the result is `op_a - op_b` modulo 2^WIDTH.
- R8: With `func_sel` = 3'b111 (compare) the result is `op_a - op_b` modulo 2^WIDTH.
- R9: On a rising clock edge with reset released and `func_sel` one of 010, 011 or 111, `zero_flag` becomes 1 if the result was all zeros and 0 otherwise.
- R10: On a rising clock edge with `func_sel` one of 000, 001, 100, 101 or 110, `zero_flag` keeps its value. A zero result does not set a cleared flag, and a nonzero result does not clear a set flag.
- R11: Driving `rst_n` low clears `zero_flag` at once, without waiting for a clock edge, and holds it cleared while low.
- R12: The result depends only on `op_a`, `op_b` and `func_sel`. It is unaffected by `rst_n` and `clk`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; the zero flag samples on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset of the zero flag |
| func_sel | input | 3 | Function code (encodings in R1 to R9) |
| op_a | input | WIDTH | First operand |
| op_b | input | WIDTH | Second operand |
| result | output | WIDTH | Combinational result word |
| zero_flag | output | 1 | Held zero flag |

## Verification
The flag assertions assume that `func_sel`, `op_a` and `op_b` are stable around each rising edge. Under that assumption, the result seen just before the edge is the value the flag captures. The bench therefore changes inputs only on falling edges. It mixes random operands with deliberately equal operand pairs, so that subtract and compare often give zero. It also sets up zero-producing bitwise cases after a flag clear, and nonzero ones after a flag set. Reset is dropped once between edges, to show that the flag clears asynchronously while the result keeps tracking its inputs.

// File: rtl/zf_alu_pkg.sv
package zf_alu_pkg;

    localparam int FUNC_W = 3;

    typedef enum logic [FUNC_W-1:0] {
        FN_AND  = 3'b000,
        FN_OR   = 3'b001,
        FN_ADD  = 3'b010,
        FN_SUB  = 3'b011,
        FN_XOR  = 3'b100,
        FN_NOTA = 3'b101,
        FN_PASB = 3'b110,
        FN_CMP  = 3'b111
    } func_e;

    typedef enum logic [1:0] {
        LG_AND,
        LG_OR,
        LG_XOR,
        LG_NOT
    } logic_op_e;

    typedef struct packed {
        logic      use_arith;
        logic      subtract;
        logic      use_pass_b;
        logic_op_e lop;
        logic      upd_flag;
    } ctrl_t;

    typedef struct packed {
        logic zero;
    } flag_st_t;

endpackage

// File: rtl/zf_alu_dec.sv
module zf_alu_dec
    import zf_alu_pkg::*;
(
    input  logic [FUNC_W-1:0] func_sel,
    output ctrl_t             ctrl
);

    always_comb begin
        ctrl = '{use_arith: 1'b0, subtract: 1'b0, use_pass_b: 1'b0,
                 lop: LG_AND, upd_flag: 1'b0};
        unique case (func_e'(func_sel))
            FN_AND:  ctrl.lop = LG_AND;
            FN_OR:   ctrl.lop = LG_OR;
            FN_XOR:  ctrl.lop = LG_XOR;
            FN_NOTA: ctrl.lop = LG_NOT;
            FN_PASB: ctrl.use_pass_b = 1'b1;
            FN_ADD: begin
                ctrl.use_arith = 1'b1;
                ctrl.upd_flag  = 1'b1;
            end
            FN_SUB, FN_CMP: begin
                ctrl.use_arith = 1'b1;
                ctrl.subtract  = 1'b1;
                ctrl.upd_flag  = 1'b1;
            end
            default: ctrl.lop = LG_AND;
        endcase
    end

endmodule

// File: rtl/zf_alu_logic.sv
module zf_alu_logic
    import zf_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic_op_e        lop,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] lg_out
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        always_comb begin
            unique case (lop)
                LG_AND:  lg_out[i] = op_a[i] & op_b[i];
                LG_OR:   lg_out[i] = op_a[i] | op_b[i];
                LG_XOR:  lg_out[i] = op_a[i] ^ op_b[i];
                LG_NOT:  lg_out[i] = ~op_a[i];
                default: lg_out[i] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/zf_alu_arith.sv
module zf_alu_arith #(
    parameter int WIDTH = 16
) (
    input  logic             subtract,
    input  logic [WIDTH-1:0] op_a,
    input  logic [WIDTH-1:0] op_b,
    output logic [WIDTH-1:0] sum
);

    localparam int EXT_W = WIDTH + 1;

    logic [WIDTH-1:0] b_eff;
    logic [EXT_W-1:0] full;

    always_comb begin
        b_eff = subtract ? ~op_b : op_b;
        full  = {1'b0, op_a} + {1'b0, b_eff} + {{WIDTH{1'b0}}, subtract};
        sum   = full[WIDTH-1:0];
    end

endmodule

// File: rtl/zf_alu_flag.sv
module zf_alu_flag
    import zf_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_flag,
    input  logic [WIDTH-1:0] res_word,
    output logic             zero_flag
);

    flag_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (upd_flag) begin
            st_d.zero = ~(|res_word);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign zero_flag = st_q.zero;

endmodule

// File: rtl/zf_alu.sv
module zf_alu
    import zf_alu_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FUNC_W-1:0] func_sel,
    input  logic [WIDTH-1:0]  op_a,
    input  logic [WIDTH-1:0]  op_b,
    output logic [WIDTH-1:0]  result,
    output logic              zero_flag
);

    ctrl_t            ctrl;
    logic [WIDTH-1:0] lg_out;
    logic [WIDTH-1:0] sum;

    zf_alu_dec u_dec (
        .func_sel (func_sel),
        .ctrl     (ctrl)
    );

    zf_alu_logic #(.WIDTH(WIDTH)) u_logic (
        .lop    (ctrl.lop),
        .op_a   (op_a),
        .op_b   (op_b),
        .lg_out (lg_out)
    );

    zf_alu_arith #(.WIDTH(WIDTH)) u_arith (
        .subtract (ctrl.subtract),
        .op_a     (op_a),
        .op_b     (op_b),
        .sum      (sum)
    );

    always_comb begin
        if (ctrl.use_arith) begin
            result = sum;
        end else if (ctrl.use_pass_b) begin
            result = op_b;
        end else begin
            result = lg_out;
        end
    end

    zf_alu_flag #(.WIDTH(WIDTH)) u_flag (
        .clk       (clk),
        .rst_n     (rst_n),
        .upd_flag  (ctrl.upd_flag),
        .res_word  (result),
        .zero_flag (zero_flag)
    );

endmodule

// File: rtl/zf_alu_chk.sv
module zf_alu_chk #(
    parameter int WIDTH = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic [2:0]       func_sel,
    input logic [WIDTH-1:0] op_a,
    input logic [WIDTH-1:0] op_b,
    input logic [WIDTH-1:0] result,
    input logic             zero_flag
);

    logic arith_fn;
    assign arith_fn = (func_sel == 3'b010) || (func_sel == 3'b011) || (func_sel == 3'b111);

    // R9: an arithmetic function loads the flag with the zero test of its result
    a_r9_flag_load: assert property (@(posedge clk) disable iff (!rst_n)
        arith_fn |=> (zero_flag == $past(result == '0)));

    // R10: bitwise and move functions keep the flag
    a_r10_flag_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !arith_fn |=> $stable(zero_flag));

    // R6: addition wraps modulo 2^WIDTH
    a_r6_add_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (func_sel == 3'b010) |-> (WIDTH'(result - op_b) == op_a));

    // R8: compare result plus B gives back A
    a_r8_cmp_diff: assert property (@(posedge clk) disable iff (!rst_n)
        (func_sel == 3'b111) |-> (WIDTH'(result + op_b) == op_a));

    // R4: inversion leaves no bit shared with A
    a_r4_not_a: assert property (@(posedge clk) disable iff (!rst_n)
        (func_sel == 3'b101) |-> ((result & op_a) == '0 && (result | op_a) == '1));

endmodule

bind zf_alu zf_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .func_sel  (func_sel),
    .op_a      (op_a),
    .op_b      (op_b),
    .result    (result),
    .zero_flag (zero_flag)
);

// File: tb/test_zf_alu.sv
`timescale 1ns/1ps
module test_zf_alu;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   func_sel = 3'b000;
    logic [W-1:0] op_a = '0;
    logic [W-1:0] op_b = '0;
    logic [W-1:0] result;
    logic         zero_flag;

    int n_tests = 0;
    int n_fail  = 0;
    bit model_z = 1'b0;
    bit done    = 1'b0;

    always #2.5 clk = ~clk;

    zf_alu #(.WIDTH(W)) i_zf_alu (
        .clk       (clk),
        .rst_n     (rst_n),
        .func_sel  (func_sel),
        .op_a      (op_a),
        .op_b      (op_b),
        .result    (result),
        .zero_flag (zero_flag)
    );

    function automatic logic [W-1:0] ref_res(input logic [2:0] f,
                                             input logic [W-1:0] a,
                                             input logic [W-1:0] b);
        case (f)
            3'd0: return a & b;
            3'd1: return a | b;
            3'd2: return a + b;
            3'd3: return a - b;
            3'd4: return a ^ b;
            3'd5: return ~a;
            3'd6: return b;
            default: return a - b;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] f);
        case (f)
            3'd0: return "R1";
            3'd1: return "R2";
            3'd2: return "R6";
            3'd3: return "R7";
            3'd4: return "R3";
            3'd5: return "R4";
            3'd6: return "R5";
            default: return "R8";
        endcase
    endfunction

    function automatic bit is_arith(input logic [2:0] f);
        return f == 3'd2 || f == 3'd3 || f == 3'd7;
    endfunction

    task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Called at a falling edge: drive, check result, cross rising edge, check flag.
    task automatic step(input logic [2:0] f, input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] e;
        func_sel = f;
        op_a     = a;
        op_b     = b;
        e        = ref_res(f, a, b);
        #1;
        chk(req_of(f), result, e);
        @(posedge clk);
        if (rst_n && is_arith(f)) model_z = (e == '0);
        #1;
        chk(is_arith(f) ? "R9" : "R10", {15'd0, zero_flag}, {15'd0, model_z});
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 5);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        @(negedge clk);
        #1;
        chk("R11", {15'd0, zero_flag}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1..R8 directed
        step(3'd0, 16'hF0F0, 16'h3C3C);
        step(3'd1, 16'hF000, 16'h000F);
        step(3'd4, 16'hAAAA, 16'hFFFF);
        step(3'd5, 16'h1234, 16'hFFFF);
        step(3'd6, 16'hBEEF, 16'h5A5A);
        step(3'd2, 16'hFFFF, 16'h0001);   // R6 wraps to zero, R9 flag set
        step(3'd0, 16'h00FF, 16'hFF00);   // R10 nonzero? no: zero result, flag stays 1
        step(3'd1, 16'h0001, 16'h0000);   // R10 nonzero result, flag stays 1
        step(3'd3, 16'h0005, 16'h0007);   // R7 negative wrap, flag cleared
        step(3'd0, 16'h0000, 16'h1111);   // R10 zero AND leaves cleared flag
        step(3'd6, 16'h1111, 16'h0000);   // R10 zero pass leaves cleared flag
        step(3'd7, 16'h4321, 16'h4321);   // R8 compare equal sets flag
        step(3'd4, 16'h7777, 16'h7777);   // R10 zero XOR keeps flag
        step(3'd7, 16'h0001, 16'h0002);   // R8 compare unequal clears flag

        // R11 / R12: asynchronous reset between edges
        step(3'd2, 16'h0000, 16'h0000);   // flag set
        #0.5;
        rst_n = 1'b0;
        #0.5;
        chk("R11", {15'd0, zero_flag}, 16'd0);
        func_sel = 3'd4;
        op_a     = 16'h0F0F;
        op_b     = 16'h00FF;
        #0.5;
        chk("R12", result, 16'h0FF0);
        model_z = 1'b0;
        @(posedge clk);
        #1;
        chk("R11", {15'd0, zero_flag}, 16'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // random mix, with equal operands half the time
        for (int i = 0; i < 400; i++) begin
            logic [2:0]   f = 3'($urandom_range(0, 7));
            logic [W-1:0] a = W'($urandom);
            logic [W-1:0] b = ($urandom_range(0, 1) != 0) ? a : W'($urandom);
            step(f, a, b);
        end

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule